// File: doc/BRIEF.md
# Serial Security-Coprocessor Register Transaction Framer

This block is the controller side of a serial link to a security coprocessor. Each request reads or writes one register of the coprocessor, and the block runs that whole transaction in a single chip-select frame. The block builds the frame from the request. It sends a header that carries the direction and the locality. For data-FIFO writes only, it adds a length field. It then sends the payload and a set number of padding bytes. These padding bytes give the coprocessor time to produce a one-byte status code.

Software or a command sequencer starts a transaction with a valid/ready handshake. The request carries the direction, the register address, the byte count and the latency setting. Write payload bytes are pulled one at a time through a pop strobe. Read data bytes come out one at a time with a valid strobe. When the frame ends, a one-cycle done pulse is raised. In that same cycle the raw status code and a two-bit error class are valid. The serial clock is a fixed division of the system clock. Bits are shifted most significant bit first, in clock mode 0.

Top module: `tpm_spi_framer`

## Requirements
- R1: The first byte sent in a frame is 0x80 for a write and 0x00 for a read, which means locality 0 with the direction in bit 7. The second byte is the 8-bit register address.
- R2: A write to address 0x24 with a nonzero byte count sends a 16-bit length right after the address, high byte first. A write to any other address, or with a count of zero, sends no length field.
- R3: A write sends its payload bytes in order after the header. It then sends exactly `latency` bytes of 0x00. The byte received during the last of these bytes becomes the status code.
- R4: A read sends 0x00 for `latency` plus `count` bytes after the header. The byte received during the last latency byte is the status code. Each of the `count` bytes received after it comes out on `rdData` with a one-cycle `rdValid`, in order.
- R5: On the done cycle, `errClass` is one of four values. It is 0 (ok) for status 0x5A, 2 (size) for 0x86 or 0x89, and 3 (no response) for 0x00. It is 1 (protocol) for every other code, including 0x80 to 0x85, 0x8A, 0x8B and 0x90. `statusCode` shows the raw status code.
- R6: A request with latency 0 or 15 produces no frame, because chip select never falls. It completes with done, `statusCode` 0x00 and `errClass` 3.
- R7: Chip select is high while the block is idle. It falls once per transaction and stays low from the first header bit to the last padding or data bit.
- R8: The serial clock idles low. MOSI changes only while the clock is low and is stable at each rising edge. Bytes are sent and received most significant bit first.
- R9: `reqReady` is high only when the block is idle. A request is taken when `reqValid` and `reqReady` are both high. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqWrite | input | 1 | 1 = register write, 0 = register read |
| reqAddr | input | 8 | Register address |
| reqLen | input | LEN_W | Payload or read byte count |
| reqLatency | input | 4 | Number of padding bytes |
| wrData | input | 8 | Next write payload byte, held by the source |
| wrPop | output | 1 | Current `wrData` taken; the source moves to the next byte |
| rdData | output | 8 | Received read data byte |
| rdValid | output | 1 | `rdData` valid for one cycle |
| done | output | 1 | Transaction finished, one-cycle pulse |
| statusCode | output | 8 | Status byte of the last transaction |
| errClass | output | 2 | Decoded class of the last status |
| spiSclk | output | 1 | Serial clock, mode 0 |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data to the device |
| spiMiso | input | 1 | Serial data from the device |

## Verification
The bench targets four edges of frame shaping.

- **Length field.** A length field must appear only for nonzero data-FIFO writes. A design that adds it to a zero-count FIFO write, or to a status-register write, shifts every later byte. The status code is then taken from the wrong slot.
- **Status position.** For reads, the status byte sits just before the data. A design that counts one slot off reports a data byte as status, or returns the status as the first data byte.
- **Status decoding.** The bench runs every class boundary, including codes that are not in any list.
- **Absent latency.** With latency set to 0 or 15, the bench confirms that no chip-select frame starts. A design that ignores this rule would clock out a frame to an absent device.

// File: rtl/tpm_frame_pkg.sv
package tpm_frame_pkg;

  localparam logic [7:0] FIFO_ADDR = 8'h24;
  localparam logic [7:0] CODE_OK   = 8'h5A;

  typedef enum logic [1:0] {
    CLS_OK     = 2'd0,
    CLS_PROTO  = 2'd1,
    CLS_SIZE   = 2'd2,
    CLS_NORESP = 2'd3
  } err_class_t;

  typedef struct packed {
    logic       load;
    logic [7:0] txByte;
    logic       csOn;
    logic       csOff;
  } dp_strobe_t;

  typedef enum logic [2:0] {
    PH_HDR0, PH_HDR1, PH_LENH, PH_LENL, PH_PAY, PH_LAT, PH_RDAT
  } phase_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_START, ST_RUN, ST_FINISH
  } state_t;

  function automatic err_class_t classify(input logic [7:0] code);
    if (code == CODE_OK)                       return CLS_OK;
    else if (code == 8'h00)                    return CLS_NORESP;
    else if (code == 8'h86 || code == 8'h89)   return CLS_SIZE;
    else                                       return CLS_PROTO;
  endfunction

endpackage

// File: rtl/tpm_frame_datapath.sv
module tpm_frame_datapath
  import tpm_frame_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  dp_strobe_t strb,
  input  logic       spiMiso,
  output logic       spiSclk,
  output logic       spiCsN,
  output logic       spiMosi,
  output logic       byteDone,
  output logic [7:0] rxByte,
  output logic       busy
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [7:0]       txShift;
  logic [7:0]       rxShift;
  logic             sclkReg;
  logic             csReg;
  logic             doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      bitCnt  <= '0;
      txShift <= '0;
      rxShift <= '0;
      sclkReg <= 1'b0;
      csReg   <= 1'b1;
      busy    <= 1'b0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (strb.csOn)  csReg <= 1'b0;
      if (strb.csOff) csReg <= 1'b1;
      if (strb.load && !busy) begin
        txShift <= strb.txByte;
        bitCnt  <= '0;
        divCnt  <= '0;
        sclkReg <= 1'b0;
        busy    <= 1'b1;
      end else if (busy) begin
        if (divCnt == DIV_LAST) begin
          divCnt <= '0;
          if (!sclkReg) begin
            sclkReg <= 1'b1;
            rxShift <= {rxShift[6:0], spiMiso};
          end else begin
            sclkReg <= 1'b0;
            if (bitCnt == 3'd7) begin
              busy    <= 1'b0;
              doneReg <= 1'b1;
            end else begin
              bitCnt  <= bitCnt + 3'd1;
              txShift <= {txShift[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign spiSclk  = sclkReg;
  assign spiCsN   = csReg;
  assign spiMosi  = txShift[7];
  assign byteDone = doneReg;
  assign rxByte   = rxShift;

  // R8: data must not move on the cycle the clock rises
  a_r8_mosi_stable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiSclk) |-> $stable(spiMosi));

  // R7: clock only toggles inside a chip-select frame
  a_r7_clk_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    spiSclk |-> !spiCsN);

endmodule

// File: rtl/tpm_frame_control.sv
module tpm_frame_control
  import tpm_frame_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [7:0]       reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [3:0]       reqLatency,
  input  logic [7:0]       wrData,
  output logic             wrPop,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             done,
  output logic [7:0]       statusCode,
  output logic [1:0]       errClass,
  output dp_strobe_t       strb,
  input  logic             byteDone,
  input  logic [7:0]       rxByte
);

  localparam int LENF_W = 16;

  state_t           state;
  phase_t           phase;
  logic [LEN_W-1:0] cnt;
  logic             isWrite;
  logic [7:0]       addrReg;
  logic [LEN_W-1:0] lenReg;
  logic [3:0]       latReg;
  logic [7:0]       statusReg;

  logic             advance;
  logic             lastInPhase;
  logic             goFinish;
  phase_t           nextPhase;
  logic [LEN_W-1:0] nextCnt;
  logic [7:0]       nextByte;
  logic [LENF_W-1:0] lenWide;

  assign lenWide     = LENF_W'(lenReg);
  assign lastInPhase = (cnt == '0);
  assign advance     = (state == ST_RUN) && byteDone;

  always_comb begin
    nextPhase = phase;
    nextCnt   = cnt - LEN_W'(1);
    nextByte  = 8'h00;
    goFinish  = 1'b0;
    wrPop     = 1'b0;
    if (state == ST_START) begin
      nextPhase = PH_HDR0;
      nextCnt   = '0;
      nextByte  = {isWrite, 7'd0};
    end else if (advance) begin
      case (phase)
        PH_HDR0: begin
          nextPhase = PH_HDR1;
          nextCnt   = '0;
          nextByte  = addrReg;
        end
        PH_HDR1: begin
          if (isWrite && lenReg != '0 && addrReg == FIFO_ADDR) begin
            nextPhase = PH_LENH;
            nextCnt   = '0;
            nextByte  = lenWide[15:8];
          end else if (isWrite && lenReg != '0) begin
            nextPhase = PH_PAY;
            nextCnt   = lenReg - LEN_W'(1);
            nextByte  = wrData;
            wrPop     = 1'b1;
          end else begin
            nextPhase = PH_LAT;
            nextCnt   = LEN_W'(latReg) - LEN_W'(1);
          end
        end
        PH_LENH: begin
          nextPhase = PH_LENL;
          nextCnt   = '0;
          nextByte  = lenWide[7:0];
        end
        PH_LENL: begin
          nextPhase = PH_PAY;
          nextCnt   = lenReg - LEN_W'(1);
          nextByte  = wrData;
          wrPop     = 1'b1;
        end
        PH_PAY: begin
          if (lastInPhase) begin
            nextPhase = PH_LAT;
            nextCnt   = LEN_W'(latReg) - LEN_W'(1);
          end else begin
            nextByte = wrData;
            wrPop    = 1'b1;
          end
        end
        PH_LAT: begin
          if (lastInPhase) begin
            if (!isWrite && lenReg != '0) begin
              nextPhase = PH_RDAT;
              nextCnt   = lenReg - LEN_W'(1);
            end else begin
              goFinish = 1'b1;
            end
          end
        end
        default: begin
          if (lastInPhase) goFinish = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strb        = '0;
    strb.csOn   = (state == ST_START);
    strb.csOff  = (state == ST_FINISH);
    strb.load   = (state == ST_START) || (advance && !goFinish);
    strb.txByte = nextByte;
  end

  assign reqReady = (state == ST_IDLE);
  assign rdValid  = advance && (phase == PH_RDAT);
  assign rdData   = rxByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phase      <= PH_HDR0;
      cnt        <= '0;
      isWrite    <= 1'b0;
      addrReg    <= '0;
      lenReg     <= '0;
      latReg     <= '0;
      statusReg  <= '0;
      done       <= 1'b0;
      statusCode <= '0;
      errClass   <= CLS_OK;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            isWrite   <= reqWrite;
            addrReg   <= reqAddr;
            lenReg    <= reqLen;
            latReg    <= reqLatency;
            statusReg <= 8'h00;
            if (reqLatency == 4'd0 || reqLatency == 4'd15) state <= ST_FINISH;
            else                                           state <= ST_START;
          end
        end
        ST_START: begin
          phase <= nextPhase;
          cnt   <= nextCnt;
          state <= ST_RUN;
        end
        ST_RUN: begin
          if (advance) begin
            if (phase == PH_LAT && lastInPhase) statusReg <= rxByte;
            if (goFinish) state <= ST_FINISH;
            phase <= nextPhase;
            cnt   <= nextCnt;
          end
        end
        default: begin
          done       <= 1'b1;
          statusCode <= statusReg;
          errClass   <= classify(statusReg);
          state      <= ST_IDLE;
        end
      endcase
    end
  end

  // R9: done lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: the block is idle again right after done
  a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);

  // R5: a success code is always reported as class ok
  a_r5_ok_class: assert property (@(posedge clk) disable iff (!rstN)
    (done && statusCode == CODE_OK) |-> (errClass == CLS_OK));

  // R4: read data only appears while busy
  a_r4_rd_busy: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !reqReady);

endmodule

// File: rtl/tpm_spi_framer.sv
module tpm_spi_framer
  import tpm_frame_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int CLK_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [7:0]       reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [3:0]       reqLatency,
  input  logic [7:0]       wrData,
  output logic             wrPop,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             done,
  output logic [7:0]       statusCode,
  output logic [1:0]       errClass,
  output logic             spiSclk,
  output logic             spiCsN,
  output logic             spiMosi,
  input  logic             spiMiso
);

  dp_strobe_t strb;
  logic       byteDone;
  logic [7:0] rxByte;
  logic       dpBusy;

  tpm_frame_control #(.LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqLatency(reqLatency),
    .wrData(wrData), .wrPop(wrPop), .rdData(rdData), .rdValid(rdValid),
    .done(done), .statusCode(statusCode), .errClass(errClass),
    .strb(strb), .byteDone(byteDone), .rxByte(rxByte)
  );

  tpm_frame_datapath #(.CLK_DIV(CLK_DIV)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .spiMiso(spiMiso),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .byteDone(byteDone), .rxByte(rxByte), .busy(dpBusy)
  );

  // R7: chip select is released whenever the block is idle and the shifter is quiet
  a_r7_idle_cs: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !dpBusy) |-> spiCsN);

endmodule

// File: tb/tpm_spi_framer_test.sv
module tpm_spi_framer_test;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [3:0] reqLatency = '0;
  logic [7:0] wrData;
  logic wrPop;
  logic [7:0] rdData;
  logic rdValid;
  logic done;
  logic [7:0] statusCode;
  logic [1:0] errClass;
  logic spiSclk, spiCsN, spiMosi;
  logic spiMiso = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [7:0] pay [64];
  logic [7:0] rsp [64];
  logic [7:0] txBytes [64];
  logic [7:0] rdGot [64];
  logic [7:0] expTx [64];
  int wrIdx = 0;
  int rdCnt = 0;
  int frames = 0;
  int sByte = 0;
  int sBit = 0;
  logic [7:0] sSh = '0;
  bit gotDone;
  logic [7:0] doneStatus;
  logic [1:0] doneClass;

  always #(CLK_PERIOD/2) clk = ~clk;

  tpm_spi_framer #(.LEN_W(LEN_W), .CLK_DIV(2)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqLatency(reqLatency), .wrData(wrData), .wrPop(wrPop),
    .rdData(rdData), .rdValid(rdValid), .done(done),
    .statusCode(statusCode), .errClass(errClass), .spiSclk(spiSclk),
    .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  assign wrData = pay[wrIdx % 64];

  always @(posedge clk) begin
    if (wrPop) wrIdx <= wrIdx + 1;
    if (rdValid) begin
      rdGot[rdCnt % 64] <= rdData;
      rdCnt <= rdCnt + 1;
    end
  end

  // device model: mode 0, MSB first
  always @(negedge spiCsN) begin
    frames = frames + 1;
    sByte = 0;
    sBit = 0;
    spiMiso = rsp[0][7];
  end

  always @(posedge spiSclk) begin
    sSh = {sSh[6:0], spiMosi};
    sBit = sBit + 1;
    if (sBit == 8) begin
      if (sByte < 64) txBytes[sByte] = sSh;
      sByte = sByte + 1;
      sBit = 0;
    end
  end

  always @(negedge spiSclk) begin
    if (!spiCsN && sByte < 64) spiMiso = rsp[sByte][7 - sBit];
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic doTxn(input bit w, input logic [7:0] a, input int n, input logic [3:0] lat);
    int guard;
    @(negedge clk);
    reqWrite = w; reqAddr = a; reqLen = LEN_W'(n); reqLatency = lat;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    gotDone = 1'b0;
    guard = 0;
    while (!gotDone && guard < 20000) begin
      if (done) begin
        gotDone = 1'b1;
        doneStatus = statusCode;
        doneClass = errClass;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    check(gotDone, "R9 done seen", int'(gotDone), 1);
    @(negedge clk);
  endtask

  task automatic fillRsp();
    for (int i = 0; i < 64; i++) rsp[i] = 8'hC3;
  endtask

  task automatic tReset();
    check(spiCsN === 1'b1, "R7 cs high at reset", int'(spiCsN), 1);
    check(spiSclk === 1'b0, "R8 sclk low at reset", int'(spiSclk), 0);
    check(reqReady === 1'b1, "R9 ready at reset", int'(reqReady), 1);
    check(done === 1'b0, "R9 no done at reset", int'(done), 0);
  endtask

  task automatic tWriteFifo();
    int f0 = frames;
    int nExp = 9;
    fillRsp();
    rsp[8] = 8'h5A;
    for (int i = 0; i < 3; i++) pay[(wrIdx + i) % 64] = 8'h11 * (i + 3);
    expTx[0] = 8'h80; expTx[1] = 8'h24; expTx[2] = 8'h00; expTx[3] = 8'h03;
    expTx[4] = 8'h33; expTx[5] = 8'h44; expTx[6] = 8'h55;
    expTx[7] = 8'h00; expTx[8] = 8'h00;
    doTxn(1'b1, 8'h24, 3, 4'd2);
    check(frames == f0 + 1, "R7 one frame", frames - f0, 1);
    check(sByte == nExp, "R3 fifo write length", sByte, nExp);
    for (int i = 0; i < nExp; i++)
      check(txBytes[i] == expTx[i], "R1 R2 R3 R8 fifo write byte", int'(txBytes[i]), int'(expTx[i]));
    check(doneStatus == 8'h5A, "R3 status", int'(doneStatus), 8'h5A);
    check(doneClass == 2'd0, "R5 ok class", int'(doneClass), 0);
  endtask

  task automatic tWriteReg();
    fillRsp();
    rsp[3] = 8'h85;
    pay[wrIdx % 64] = 8'h40;
    doTxn(1'b1, 8'h18, 1, 4'd1);
    check(sByte == 4, "R2 no length field for reg write", sByte, 4);
    check(txBytes[0] == 8'h80, "R1 write header", int'(txBytes[0]), 8'h80);
    check(txBytes[1] == 8'h18, "R1 address", int'(txBytes[1]), 8'h18);
    check(txBytes[2] == 8'h40, "R3 payload", int'(txBytes[2]), 8'h40);
    check(txBytes[3] == 8'h00, "R3 latency pad", int'(txBytes[3]), 0);
    check(doneClass == 2'd1, "R5 protocol 0x85", int'(doneClass), 1);
  endtask

  task automatic tFifoZero();
    fillRsp();
    rsp[3] = 8'h89;
    doTxn(1'b1, 8'h24, 0, 4'd2);
    check(sByte == 4, "R2 zero-count fifo write has no length", sByte, 4);
    check(txBytes[2] == 8'h00 && txBytes[3] == 8'h00, "R2 pads follow address",
          int'({txBytes[2], txBytes[3]}), 0);
    check(doneStatus == 8'h89 && doneClass == 2'd2, "R5 size 0x89",
          int'({doneStatus, 6'd0, doneClass}), 16'h8902);
  endtask

  task automatic tRead();
    int base = rdCnt;
    fillRsp();
    rsp[2] = 8'hEE; rsp[3] = 8'hEE; rsp[4] = 8'h86;
    rsp[5] = 8'hA1; rsp[6] = 8'hB2; rsp[7] = 8'hC3; rsp[8] = 8'hD4;
    doTxn(1'b0, 8'h14, 4, 4'd3);
    check(sByte == 9, "R4 read frame length", sByte, 9);
    check(txBytes[0] == 8'h00, "R1 read header", int'(txBytes[0]), 0);
    check(txBytes[1] == 8'h14, "R1 read address", int'(txBytes[1]), 8'h14);
    for (int i = 2; i < 9; i++)
      check(txBytes[i] == 8'h00, "R4 read sends zero", int'(txBytes[i]), 0);
    check(rdCnt - base == 4, "R4 data count", rdCnt - base, 4);
    for (int i = 0; i < 4; i++)
      check(rdGot[(base + i) % 64] == rsp[5 + i], "R4 read data", int'(rdGot[(base + i) % 64]), int'(rsp[5 + i]));
    check(doneStatus == 8'h86, "R4 status before data", int'(doneStatus), 8'h86);
    check(doneClass == 2'd2, "R5 size 0x86", int'(doneClass), 2);
  endtask

  task automatic tClasses();
    logic [7:0] codes [8] = '{8'h00, 8'h80, 8'h8A, 8'h8B, 8'h90, 8'h89, 8'h5A, 8'h7F};
    logic [1:0] exps [8]  = '{2'd3, 2'd1, 2'd1, 2'd1, 2'd1, 2'd2, 2'd0, 2'd1};
    for (int k = 0; k < 8; k++) begin
      fillRsp();
      rsp[2] = codes[k];
      doTxn(1'b0, 8'h00, 0, 4'd1);
      check(doneStatus == codes[k], "R5 raw status", int'(doneStatus), int'(codes[k]));
      check(doneClass == exps[k], "R5 class", int'(doneClass), int'(exps[k]));
    end
  endtask

  task automatic tAbsent();
    int f0 = frames;
    doTxn(1'b0, 8'h14, 1, 4'd15);
    check(frames == f0, "R6 no frame at latency 15", frames - f0, 0);
    check(doneClass == 2'd3 && doneStatus == 8'h00, "R6 no-response",
          int'({doneStatus, 6'd0, doneClass}), 3);
    doTxn(1'b1, 8'h18, 1, 4'd0);
    check(frames == f0, "R6 no frame at latency 0", frames - f0, 0);
    check(doneClass == 2'd3, "R6 class at latency 0", int'(doneClass), 3);
  endtask

  task automatic tBusyReady();
    fillRsp();
    rsp[2] = 8'h5A;
    @(negedge clk);
    reqWrite = 1'b0; reqAddr = 8'h18; reqLen = LEN_W'(0); reqLatency = 4'd1;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (10) @(negedge clk);
    check(reqReady == 1'b0, "R9 not ready while busy", int'(reqReady), 0);
    check(spiCsN == 1'b0, "R7 cs low mid frame", int'(spiCsN), 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(reqReady == 1'b1, "R9 ready after done", int'(reqReady), 1);
    check(done == 1'b0, "R9 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      pay[i] = 8'h00; rsp[i] = 8'hC3; txBytes[i] = 8'h00; rdGot[i] = 8'h00; expTx[i] = 8'h00;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWriteFifo();
    tWriteReg();
    tFifoZero();
    tRead();
    tClasses();
    tAbsent();
    tBusyReady();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule